// File: doc/BRIEF.md
# Split Placement and Migration Selector

This block sits in the controller of a last-level cache built from several equal splits, where each requesting core owns a subset of the splits. After the lookup for a request finishes, the selector decides where the block goes. On a miss in every split, the block is filled into one of the requester's own splits, chosen at random. On a hit in a split the requester does not own, the block is moved into one of the requester's splits, also chosen at random. The old copy is invalidated so the cache never holds two copies of the same block. A hit in the requester's own splits needs no action.

The result is one cycle wide. It appears in the cycle after the request, as a strobe with a one-hot target split and a one-hot invalidate vector. The set index inside the chosen split still comes from the block address, so it is not an output of this block. The random choice comes from a free-running 16-bit LFSR. The LFSR value is reduced modulo the number of assigned splits, and the result picks among the mask's set bits in ascending index order.

Top module: `placementSelector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `placeValid`, `targetSplit` and `invalSplit` are all zero.
- R2: The 2-bit `lookupOutcome` code is 0 for a hit in an assigned split, 1 for a hit in an unassigned split, 2 for a miss everywhere and 3 for reserved. Codes 0 and 3 never produce a strobe.
- R3: A request with code 2 and a non-empty mask raises `placeValid` exactly one cycle later. `targetSplit` is then one-hot with its bit inside the request's mask, and `invalSplit` is zero.
- R4: A request with code 1 whose `holderSplit` index is outside the non-empty mask raises `placeValid` one cycle later. `targetSplit` is then one-hot inside the mask, and `invalSplit` has only bit `holderSplit` set.
- R5: A request with code 1 whose `holderSplit` index is already inside the mask produces no strobe and no invalidate.
- R6: A request with an all-zero mask produces no strobe, whatever its code.
- R7: When the mask has exactly one bit set, a fill or move targets that split.
- R8: The choice is spread over all set bits of the mask. Over 300 fills with a three-bit mask, each of the three splits is chosen at least 30 times.
- R9: The strobe lasts one cycle. In any cycle without `placeValid`, `targetSplit` and `invalSplit` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A finished lookup is presented this cycle |
| lookupOutcome | input | 2 | Outcome code (see R2) |
| assignMask | input | NUM_SPLITS | Splits owned by the requester |
| holderSplit | input | clog2(NUM_SPLITS) | Index of the split holding the block on an unassigned hit |
| placeValid | output | 1 | One-cycle strobe for a fill or move |
| targetSplit | output | NUM_SPLITS | One-hot destination split |
| invalSplit | output | NUM_SPLITS | One-hot split to invalidate on a move, else zero |

## Verification
The hardest case to reach from the ports is the random spread. The LFSR is internal and advances every cycle, so a single request cannot show whether every owned split is reachable. The stimulus therefore repeats fills with a fixed three-bit mask at random spacing and counts the hits per split. Single-bit masks pin the outcome for exact checks. Unassigned hits are driven with holder indices both inside and outside the mask, so that the move path and the no-move path are both exercised.

// File: rtl/placementPkg.sv
package placementPkg;

  typedef enum logic [1:0] {
    OUT_LOCAL_HIT  = 2'd0,
    OUT_REMOTE_HIT = 2'd1,
    OUT_FULL_MISS  = 2'd2,
    OUT_RESERVED   = 2'd3
  } lookupOutcome_e;

  typedef struct packed {
    logic doFill;
    logic doMove;
  } selCmd_t;

endpackage

// File: rtl/placementCtrl.sv
module placementCtrl
  import placementPkg::*;
#(
  parameter int NUM_SPLITS = 8,
  localparam int IDX_W = $clog2(NUM_SPLITS)
) (
  input  logic                  lookupValid,
  input  logic [1:0]            lookupOutcome,
  input  logic [NUM_SPLITS-1:0] assignMask,
  input  logic [IDX_W-1:0]      holderSplit,
  output selCmd_t               cmd
);

  logic maskNonEmpty;
  logic holderOwned;

  always_comb begin
    maskNonEmpty = |assignMask;
    holderOwned  = assignMask[holderSplit];
    cmd          = '0;
    if (lookupValid && maskNonEmpty) begin
      unique case (lookupOutcome_e'(lookupOutcome))
        OUT_FULL_MISS:  cmd.doFill = 1'b1;
        OUT_REMOTE_HIT: cmd.doMove = !holderOwned;
        default:        cmd = '0;
      endcase
    end
  end

endmodule

// File: rtl/placementDatapath.sv
module placementDatapath
  import placementPkg::*;
#(
  parameter int          NUM_SPLITS = 8,
  parameter int          LFSR_W     = 16,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1,
  parameter logic [15:0] LFSR_TAPS  = 16'hB400,
  localparam int IDX_W = $clog2(NUM_SPLITS),
  localparam int CNT_W = $clog2(NUM_SPLITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  selCmd_t               cmd,
  input  logic [NUM_SPLITS-1:0] assignMask,
  input  logic [IDX_W-1:0]      holderSplit,
  output logic                  placeValid,
  output logic [NUM_SPLITS-1:0] targetSplit,
  output logic [NUM_SPLITS-1:0] invalSplit
);

  logic [LFSR_W-1:0]     lfsrQ;
  logic [LFSR_W-1:0]     lfsrNext;
  logic [CNT_W-1:0]      setCount;
  logic [LFSR_W-1:0]     divisor;
  logic [LFSR_W-1:0]     remIdx;
  logic [NUM_SPLITS-1:0] pickOneHot;
  logic [NUM_SPLITS-1:0] holderOneHot;

  // Galois LFSR, advances every cycle
  always_comb begin
    lfsrNext = lfsrQ >> 1;
    if (lfsrQ[0]) lfsrNext = lfsrNext ^ LFSR_TAPS[LFSR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lfsrQ <= LFSR_SEED[LFSR_W-1:0];
    else        lfsrQ <= lfsrNext;
  end

  // population count of the mask
  always_comb begin
    setCount = '0;
    for (int i = 0; i < NUM_SPLITS; i++) begin
      setCount = setCount + CNT_W'(assignMask[i]);
    end
  end

  // reduce random value to an ordinal among set bits
  always_comb begin
    divisor = (setCount == '0) ? LFSR_W'(1) : LFSR_W'(setCount);
    remIdx  = lfsrQ % divisor;
  end

  // locate the remIdx-th set bit, lowest index first
  always_comb begin
    int seen;
    seen       = 0;
    pickOneHot = '0;
    for (int i = 0; i < NUM_SPLITS; i++) begin
      if (assignMask[i]) begin
        if (seen == int'(remIdx)) pickOneHot[i] = 1'b1;
        seen = seen + 1;
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_SPLITS; g++) begin : gHolder
      assign holderOneHot[g] = (holderSplit == IDX_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      placeValid  <= 1'b0;
      targetSplit <= '0;
      invalSplit  <= '0;
    end else begin
      placeValid  <= cmd.doFill | cmd.doMove;
      targetSplit <= (cmd.doFill | cmd.doMove) ? pickOneHot : '0;
      invalSplit  <= cmd.doMove ? holderOneHot : '0;
    end
  end

endmodule

// File: rtl/placementSelector.sv
module placementSelector
  import placementPkg::*;
#(
  parameter int NUM_SPLITS = 8,
  localparam int IDX_W = $clog2(NUM_SPLITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lookupValid,
  input  logic [1:0]            lookupOutcome,
  input  logic [NUM_SPLITS-1:0] assignMask,
  input  logic [IDX_W-1:0]      holderSplit,
  output logic                  placeValid,
  output logic [NUM_SPLITS-1:0] targetSplit,
  output logic [NUM_SPLITS-1:0] invalSplit
);

  selCmd_t cmd;

  placementCtrl #(.NUM_SPLITS(NUM_SPLITS)) uCtrl (
    .lookupValid  (lookupValid),
    .lookupOutcome(lookupOutcome),
    .assignMask   (assignMask),
    .holderSplit  (holderSplit),
    .cmd          (cmd)
  );

  placementDatapath #(.NUM_SPLITS(NUM_SPLITS)) uData (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .assignMask (assignMask),
    .holderSplit(holderSplit),
    .placeValid (placeValid),
    .targetSplit(targetSplit),
    .invalSplit (invalSplit)
  );

endmodule

// File: rtl/placementSelectorChecker.sv
module placementSelectorChecker #(
  parameter int NUM_SPLITS = 8,
  localparam int IDX_W = $clog2(NUM_SPLITS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lookupValid,
  input logic [1:0]            lookupOutcome,
  input logic [NUM_SPLITS-1:0] assignMask,
  input logic [IDX_W-1:0]      holderSplit,
  input logic                  placeValid,
  input logic [NUM_SPLITS-1:0] targetSplit,
  input logic [NUM_SPLITS-1:0] invalSplit
);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !placeValid |-> (targetSplit == '0 && invalSplit == '0));

  assert_target_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    placeValid |-> $countones(targetSplit) == 1);

  assert_target_in_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    placeValid |-> (targetSplit & ~$past(assignMask)) == '0);

  assert_no_action_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lookupValid) && ($past(lookupOutcome) == 2'd0 || $past(lookupOutcome) == 2'd3))
      |-> !placeValid);

  assert_owned_holder_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lookupValid) && $past(lookupOutcome) == 2'd1 && $past(assignMask[holderSplit]))
      |-> (!placeValid && invalSplit == '0));

  assert_empty_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(assignMask) == '0) |-> !placeValid);

  assert_strobe_needs_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    placeValid |-> $past(lookupValid));

  assert_move_inval_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (placeValid && $past(lookupOutcome) == 2'd1)
      |-> (invalSplit == (NUM_SPLITS'(1) << $past(holderSplit))));

endmodule

bind placementSelector placementSelectorChecker #(.NUM_SPLITS(NUM_SPLITS)) uChk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lookupValid  (lookupValid),
  .lookupOutcome(lookupOutcome),
  .assignMask   (assignMask),
  .holderSplit  (holderSplit),
  .placeValid   (placeValid),
  .targetSplit  (targetSplit),
  .invalSplit   (invalSplit)
);

// File: tb/tb_placementSelector.sv
module tb_placementSelector;

  localparam int N          = 8;
  localparam int IDX_W      = $clog2(N);
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           lookupValid = 1'b0;
  logic [1:0]     lookupOutcome = 2'd0;
  logic [N-1:0]   assignMask = '0;
  logic [IDX_W-1:0] holderSplit = '0;
  logic           placeValid;
  logic [N-1:0]   targetSplit;
  logic [N-1:0]   invalSplit;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  placementSelector #(.NUM_SPLITS(N)) dut (
    .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid),
    .lookupOutcome(lookupOutcome), .assignMask(assignMask),
    .holderSplit(holderSplit), .placeValid(placeValid),
    .targetSplit(targetSplit), .invalSplit(invalSplit)
  );

  function automatic bit expStrobe(logic v, logic [1:0] oc, logic [N-1:0] m, logic [IDX_W-1:0] h);
    if (!v || m == '0) return 1'b0;
    if (oc == 2'd2) return 1'b1;
    if (oc == 2'd1) return !m[h];
    return 1'b0;
  endfunction

  function automatic logic [N-1:0] expInval(logic v, logic [1:0] oc, logic [N-1:0] m, logic [IDX_W-1:0] h);
    if (expStrobe(v, oc, m, h) && oc == 2'd1) return N'(1) << h;
    return '0;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one request at a negedge, check its result at the next negedge
  task automatic doReq(logic v, logic [1:0] oc, logic [N-1:0] m, logic [IDX_W-1:0] h, string req);
    bit es;
    logic [N-1:0] ei;
    @(negedge clk);
    lookupValid = v; lookupOutcome = oc; assignMask = m; holderSplit = h;
    es = expStrobe(v, oc, m, h);
    ei = expInval(v, oc, m, h);
    @(negedge clk);
    lookupValid = 1'b0;
    check(placeValid == es, req, "strobe", 32'(placeValid), 32'(es));
    check(invalSplit == ei, req, "inval", 32'(invalSplit), 32'(ei));
    if (es) begin
      check($countones(targetSplit) == 1 && (targetSplit & ~m) == '0, req,
            "target in mask", 32'(targetSplit), 32'(m));
      if ($countones(m) == 1)
        check(targetSplit == m, "R7", "single-split target", 32'(targetSplit), 32'(m));
    end else begin
      check(targetSplit == '0, "R9", "target idle", 32'(targetSplit), 32'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int hits [N];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    check(placeValid == 1'b0 && targetSplit == '0 && invalSplit == '0, "R1",
          "reset outputs", 32'(placeValid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(placeValid == 1'b0 && targetSplit == '0 && invalSplit == '0, "R1",
          "after reset", 32'(targetSplit), 32'd0);

    // directed corner cases
    doReq(1'b1, 2'd0, 8'hFF, 3'd0, "R2");   // hit in owned split
    doReq(1'b1, 2'd3, 8'hFF, 3'd2, "R2");   // reserved code
    doReq(1'b1, 2'd2, 8'h0F, 3'd0, "R3");
    doReq(1'b1, 2'd1, 8'h03, 3'd6, "R4");
    doReq(1'b1, 2'd1, 8'h30, 3'd5, "R5");   // holder already owned
    doReq(1'b1, 2'd2, 8'h00, 3'd1, "R6");
    doReq(1'b1, 2'd1, 8'h00, 3'd1, "R6");
    doReq(1'b1, 2'd2, 8'h40, 3'd0, "R7");
    doReq(1'b1, 2'd1, 8'h01, 3'd7, "R7");
    doReq(1'b0, 2'd2, 8'hFF, 3'd0, "R9");   // no request, no strobe

    // R8: spread over a three-split mask with random spacing
    foreach (hits[i]) hits[i] = 0;
    for (int t = 0; t < 300; t++) begin
      doReq(1'b1, 2'd2, 8'b1010_0100, 3'd0, "R3");
      for (int i = 0; i < N; i++) if (targetSplit[i]) hits[i]++;
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    check(hits[2] >= 30, "R8", "split 2 count", 32'(hits[2]), 32'd30);
    check(hits[5] >= 30, "R8", "split 5 count", 32'(hits[5]), 32'd30);
    check(hits[7] >= 30, "R8", "split 7 count", 32'(hits[7]), 32'd30);

    // constrained random mix
    for (int t = 0; t < 600; t++) begin
      logic [1:0] oc;
      logic [N-1:0] m;
      logic [IDX_W-1:0] h;
      oc = 2'($urandom_range(0, 3));
      m  = ($urandom_range(0, 9) == 0) ? '0 : N'($urandom);
      h  = IDX_W'($urandom);
      doReq(($urandom_range(0, 7) != 0), oc, m, h, (oc == 2'd1) ? "R4" : "R3");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule